// File: doc/BRIEF.md
# Four-Sample Serial Receive Path

This block is the receive half of an asynchronous serial port. An external rate generator supplies a strobe four times per bit period. At each strobe the block takes one sample of the serial line, after two synchronizing flops. A falling edge on an idle high line opens start-bit qualification. A frame begins only when all four samples of the start bit are low. Every later bit also takes four samples. The bit value is the majority of those samples, with a two-two tie counting as one. Any disagreement among the four samples raises a one-cycle mismatch indication.

The received frame collects in a 12-bit shift register. Its shape comes from configuration inputs that are latched when the start bit is confirmed: five to eight data bits, an optional parity bit, and one or two stop bits. When the frame completes, the data bits go to an 8-bit holding register, but only if that register is empty. From the holding register the byte moves into a 16-entry FIFO whenever the FIFO has room. A read strobe puts the oldest byte on the parallel output. The raw parity and stop bits of each frame go out with a completion pulse to a separate status block. That block also sees the FIFO full and empty flags.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, fifo_empty is 1, fifo_full is 0, rd_data is 0, and frame_done and sample_mismatch are 0.
- R2: A frame starts only when the line was high at one sample strobe and is low at the next, and the following three samples are also low. If any of those start samples is high, the receiver returns to idle, stores no byte and pulses no frame_done.
- R3: The cfg_wlen field gives 5 + cfg_wlen data bits (0 means 5 bits, 3 means 8 bits). Data arrives least significant bit first. Bits of rd_data above the word length read as 0.
- R4: With cfg_par_en set, one parity bit follows the data. Its raw value appears on frame_par_bit, and frame_par_bit is 0 when parity is off. frame_stop_bits[0] carries the first stop bit. frame_stop_bits[1] carries the second stop bit when cfg_two_stop is 1, and reads 1 otherwise. None of these bits changes the data byte.
- R5: For every bit after the start bit, samples that do not all agree give one sample_mismatch pulse. The bit then takes the value 1 when at least two of its samples are 1.
- R6: A finished frame's data enters the holding register only when that register is empty. A frame that finishes while the register is occupied is discarded.
- R7: The holding register passes its byte into the FIFO when the FIFO is not full. The FIFO holds 16 bytes, and fifo_full and fifo_empty are never both set.
- R8: A read strobe while the FIFO is not empty puts the oldest byte on rd_data at the next clock edge. rd_data does not change at any other time.
- R9: frame_done pulses for exactly one cycle for each completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Sample strobe, four per bit period |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| cfg_wlen | input | 2 | Data bits minus five |
| cfg_par_en | input | 1 | Frame carries a parity bit |
| cfg_two_stop | input | 1 | Frame carries two stop bits |
| rd_strobe | input | 1 | Pop the oldest byte onto rd_data |
| rd_data | output | 8 | Parallel output byte |
| fifo_full | output | 1 | FIFO holds 16 bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| frame_done | output | 1 | One-cycle pulse at the end of each frame |
| frame_par_bit | output | 1 | Raw received parity bit |
| frame_stop_bits | output | 2 | Raw received stop bits |
| sample_mismatch | output | 1 | Pulse when a bit's four samples disagree |

## Verification
The assertions check four things on every cycle: FIFO flag consistency, that a full FIFO stays full until it is read, the single-cycle completion pulse, and that rd_data holds between pops. Only the bench's scenarios can show the rest. These are the sweep over every word length, parity and stop-bit combination, start qualification rejecting a short low glitch, majority resolution of a split bit, and the overflow case where the seventeenth byte waits in the holding register and the eighteenth is dropped.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  localparam int unsigned SPB      = 4;   // samples per bit
  localparam int unsigned RSR_W    = 12;  // receive shift register width
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned MIN_DATA = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/uart_os_sampler.sv
module uart_os_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  output logic smp_stb,
  output logic smp_bit
);
  logic sync1_q, sync2_q;
  logic stb_q, bit_q;
  logic bit_n;

  always_comb begin
    bit_n = bit_q;
    if (tick) bit_n = sync2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      stb_q   <= 1'b0;
      bit_q   <= 1'b1;
    end else begin
      sync1_q <= line_in;
      sync2_q <= sync1_q;
      stb_q   <= tick;
      bit_q   <= bit_n;
    end
  end

  assign smp_stb = stb_q;
  assign smp_bit = bit_q;
endmodule

// File: rtl/uart_os_frame.sv
module uart_os_frame
  import uart_os_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic              smp_bit,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_two_stop,
  output logic              frm_done,
  output logic [BYTE_W-1:0] frm_data,
  output logic              frm_par,
  output logic [1:0]        frm_stop,
  output logic              frm_mism
);
  localparam int unsigned SUB_W = $clog2(SPB);
  localparam int unsigned IDX_W = $clog2(RSR_W);
  localparam int unsigned CNT_W = $clog2(SPB + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SPB - 1);

  rx_state_e           state_q, state_n;
  logic [SUB_W-1:0]    sub_q, sub_n;
  logic [IDX_W-1:0]    idx_q, idx_n;
  logic [CNT_W-1:0]    ones_q, ones_n;
  logic [RSR_W-1:0]    rsr_q, rsr_n;
  logic                prev_q, prev_n;
  logic [1:0]          wl_q, wl_n;
  logic                pe_q, pe_n;
  logic                ts_q, ts_n;
  logic                done_n, mism_n;
  logic [CNT_W-1:0]    total;
  logic [IDX_W-1:0]    last_idx;

  logic [BYTE_W-1:0]   data_n;
  logic                par_n;
  logic [1:0]          stop_n;
  logic [IDX_W-1:0]    nbits, s0;

  logic                done_q, mism_q, par_q;
  logic [BYTE_W-1:0]   data_q;
  logic [1:0]          stop_q;

  assign last_idx = IDX_W'(MIN_DATA) + IDX_W'(wl_q) + IDX_W'(pe_q) + (ts_q ? IDX_W'(2) : IDX_W'(1));
  assign total    = ones_q + CNT_W'(smp_bit);

  always_comb begin
    state_n = state_q;
    sub_n   = sub_q;
    idx_n   = idx_q;
    ones_n  = ones_q;
    rsr_n   = rsr_q;
    prev_n  = prev_q;
    wl_n    = wl_q;
    pe_n    = pe_q;
    ts_n    = ts_q;
    done_n  = 1'b0;
    mism_n  = 1'b0;
    if (smp_stb) begin
      case (state_q)
        ST_IDLE: begin
          prev_n = smp_bit;
          if (prev_q && !smp_bit) begin
            state_n = ST_START;
            sub_n   = SUB_W'(1);
          end
        end
        ST_START: begin
          if (smp_bit) begin
            state_n = ST_IDLE;
            prev_n  = 1'b1;
          end else if (sub_q == SUB_LAST) begin
            state_n = ST_BITS;
            sub_n   = '0;
            idx_n   = IDX_W'(1);
            ones_n  = '0;
            rsr_n   = '0;
            wl_n    = cfg_wlen;
            pe_n    = cfg_par_en;
            ts_n    = cfg_two_stop;
          end else begin
            sub_n = sub_q + SUB_W'(1);
          end
        end
        ST_BITS: begin
          if (sub_q == SUB_LAST) begin
            rsr_n[idx_q] = (total >= CNT_W'(SPB / 2));
            mism_n       = (total != '0) && (total != CNT_W'(SPB));
            ones_n       = '0;
            sub_n        = '0;
            idx_n        = idx_q + IDX_W'(1);
            if (idx_q == last_idx) begin
              state_n = ST_IDLE;
              prev_n  = smp_bit;
              done_n  = 1'b1;
            end
          end else begin
            ones_n = total;
            sub_n  = sub_q + SUB_W'(1);
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  // Field extraction from the completed frame
  always_comb begin
    nbits = IDX_W'(MIN_DATA) + IDX_W'(wl_q);
    for (int i = 0; i < BYTE_W; i++) begin
      data_n[i] = (IDX_W'(i) < nbits) ? rsr_n[i+1] : 1'b0;
    end
    par_n     = pe_q ? rsr_n[nbits + IDX_W'(1)] : 1'b0;
    s0        = nbits + IDX_W'(1) + IDX_W'(pe_q);
    stop_n[0] = rsr_n[s0];
    stop_n[1] = ts_q ? rsr_n[s0 + IDX_W'(1)] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      ones_q  <= '0;
      rsr_q   <= '0;
      prev_q  <= 1'b1;
      wl_q    <= '0;
      pe_q    <= 1'b0;
      ts_q    <= 1'b0;
      done_q  <= 1'b0;
      mism_q  <= 1'b0;
      data_q  <= '0;
      par_q   <= 1'b0;
      stop_q  <= 2'b11;
    end else begin
      state_q <= state_n;
      sub_q   <= sub_n;
      idx_q   <= idx_n;
      ones_q  <= ones_n;
      rsr_q   <= rsr_n;
      prev_q  <= prev_n;
      wl_q    <= wl_n;
      pe_q    <= pe_n;
      ts_q    <= ts_n;
      done_q  <= done_n;
      mism_q  <= mism_n;
      if (done_n) begin
        data_q <= data_n;
        par_q  <= par_n;
        stop_q <= stop_n;
      end
    end
  end

  assign frm_done = done_q;
  assign frm_data = data_q;
  assign frm_par  = par_q;
  assign frm_stop = stop_q;
  assign frm_mism = mism_q;
endmodule

// File: rtl/uart_os_hold.sv
module uart_os_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_req,
  input  logic [W-1:0] load_data,
  input  logic         sink_full,
  output logic         push,
  output logic [W-1:0] push_data
);
  logic         valid_q, valid_n;
  logic [W-1:0] data_q;
  logic         accept;

  assign accept = load_req && !valid_q;
  assign push   = valid_q && !sink_full;

  always_comb begin
    valid_n = valid_q;
    if (accept)    valid_n = 1'b1;
    else if (push) valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_n;
      if (accept) data_q <= load_data;
    end
  end

  assign push_data = data_q;
endmodule

// File: rtl/uart_os_fifo.sv
module uart_os_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop_req,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW:0]   wptr_q, wptr_n, rptr_q, rptr_n;
  logic [W-1:0]  out_q, out_n;
  logic          wr_en, rd_en;

  assign full  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign empty = (wptr_q == rptr_q);
  assign wr_en = push && !full;
  assign rd_en = pop_req && !empty;

  always_comb begin
    wptr_n = wr_en ? wptr_q + 1'b1 : wptr_q;
    rptr_n = rd_en ? rptr_q + 1'b1 : rptr_q;
    out_n  = rd_en ? mem_q[rptr_q[AW-1:0]] : out_q;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wptr_q[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      out_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      out_q  <= out_n;
    end
  end

  assign pop_data = out_q;
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rx_serial,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_two_stop,
  input  logic              rd_strobe,
  output logic [BYTE_W-1:0] rd_data,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              frame_done,
  output logic              frame_par_bit,
  output logic [1:0]        frame_stop_bits,
  output logic              sample_mismatch
);
  logic              smp_stb, smp_bit;
  logic [BYTE_W-1:0] frm_data;
  logic              push;
  logic [BYTE_W-1:0] push_data;

  uart_os_sampler u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sample_tick),
    .line_in (rx_serial),
    .smp_stb (smp_stb),
    .smp_bit (smp_bit)
  );

  uart_os_frame u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_stb      (smp_stb),
    .smp_bit      (smp_bit),
    .cfg_wlen     (cfg_wlen),
    .cfg_par_en   (cfg_par_en),
    .cfg_two_stop (cfg_two_stop),
    .frm_done     (frame_done),
    .frm_data     (frm_data),
    .frm_par      (frame_par_bit),
    .frm_stop     (frame_stop_bits),
    .frm_mism     (sample_mismatch)
  );

  uart_os_hold #(.W(BYTE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (frame_done),
    .load_data (frm_data),
    .sink_full (fifo_full),
    .push      (push),
    .push_data (push_data)
  );

  uart_os_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop_req   (rd_strobe),
    .pop_data  (rd_data),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic [7:0] rd_data,
  input logic       fifo_full,
  input logic       fifo_empty,
  input logic       frame_done
);
  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  // R7
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !rd_strobe) |=> fifo_full);

  // R8
  rd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe || fifo_empty) |=> $stable(rd_data));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind uart_os_rx uart_os_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_strobe  (rd_strobe),
  .rd_data    (rd_data),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .frame_done (frame_done)
);

// File: tb/uart_os_rx_tb.sv
module uart_os_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_serial = 1'b1;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic       fifo_full, fifo_empty, frame_done, frame_par_bit, sample_mismatch;
  logic [1:0] frame_stop_bits;
  logic [1:0] tcnt = 2'd0;
  logic       sample_tick;

  int tests = 0, fails = 0, done_cnt = 0, mism_cnt = 0;
  logic       last_par;
  logic [1:0] last_stop;

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign sample_tick = (tcnt == 2'd3);

  uart_os_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_serial(rx_serial),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_two_stop(cfg_two_stop),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .frame_done(frame_done), .frame_par_bit(frame_par_bit),
    .frame_stop_bits(frame_stop_bits), .sample_mismatch(sample_mismatch)
  );

  always @(negedge clk) begin
    if (frame_done) begin
      done_cnt++;
      last_par  = frame_par_bit;
      last_stop = frame_stop_bits;
    end
    if (sample_mismatch) mism_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic align();
    @(negedge clk);
    while (tcnt != 2'd0) @(negedge clk);
  endtask

  task automatic quarters(input logic v, input int n);
    rx_serial = v;
    repeat (4 * n) @(negedge clk);
  endtask

  // split: samples v,v,~v,~v
  task automatic send_bit(input logic v, input bit split);
    if (split) begin
      quarters(v, 2);
      quarters(~v, 2);
    end else quarters(v, 4);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] wl, input bit pe,
                            input logic pbit, input bit ts, input logic [1:0] stops,
                            input int split_idx);
    int nb;
    nb = 5 + wl;
    cfg_wlen = wl; cfg_par_en = pe; cfg_two_stop = ts;
    align();
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i], split_idx == i);
    if (pe) send_bit(pbit, 1'b0);
    send_bit(stops[0], 1'b0);
    if (ts) send_bit(stops[1], 1'b0);
    quarters(1'b1, 6);
  endtask

  task automatic read_byte(output logic [7:0] v);
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    v = rd_data;
  endtask

  function automatic logic [7:0] mask_of(input logic [1:0] wl);
    return 8'((9'h1 << (5 + wl)) - 9'h1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] got, exp, d;
    int dc, mc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
    check(fifo_full == 1'b0, "R1 full", fifo_full, 0);
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    check(frame_done == 1'b0 && sample_mismatch == 1'b0, "R1 pulses", frame_done, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R3 R4 sweep over all formats
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int k = 0; k < 3; k++) begin
        logic [1:0] wl; bit pe, ts; logic pb; logic [1:0] st;
        wl = cfg[1:0]; pe = cfg[2]; ts = cfg[3];
        d  = 8'(8'hA7 + cfg * 37 + k * 91);
        pb = ^(d & mask_of(wl)) ^ k[0];
        st = (k == 2) ? 2'b01 : 2'b11;
        dc = done_cnt; mc = mism_cnt;
        send_frame(d, wl, pe, pb, ts, st, -1);
        check(done_cnt == dc + 1, "R9 one done per frame", done_cnt - dc, 1);
        check(mism_cnt == mc, "R5 no mismatch on clean frame", mism_cnt - mc, 0);
        check(last_par == (pe ? pb : 1'b0), "R4 parity raw", last_par, pe ? pb : 1'b0);
        check(last_stop == (ts ? st : {1'b1, st[0]}), "R4 stop raw", last_stop,
              ts ? st : {1'b1, st[0]});
        read_byte(got);
        exp = d & mask_of(wl);
        check(got == exp, "R3 data and upper zero", got, exp);
        check(fifo_empty == 1'b1, "R7 empty after read", fifo_empty, 1);
      end
    end

    // R3 all byte values at 8 bits, no parity, one stop
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 2'd3, 1'b0, 1'b0, 1'b0, 2'b11, -1);
      read_byte(got);
      check(got == 8'(v), "R3 full byte sweep", got, v);
    end

    // R2 start glitch: low for two samples only
    dc = done_cnt;
    align();
    quarters(1'b0, 2);
    quarters(1'b1, 12);
    check(done_cnt == dc, "R2 glitch gives no frame", done_cnt - dc, 0);
    check(fifo_empty == 1'b1, "R2 glitch stores nothing", fifo_empty, 1);
    align();
    quarters(1'b0, 3);
    quarters(1'b1, 12);
    check(fifo_empty == 1'b1, "R2 three-sample glitch", fifo_empty, 1);
    send_frame(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, 2'b11, -1);
    read_byte(got);
    check(got == 8'h3C, "R2 frame after glitch", got, 8'h3C);

    // R5 split bits resolve to 1 with one mismatch pulse
    for (int b = 0; b < 8; b++) begin
      mc = mism_cnt;
      send_frame(8'h00, 2'd3, 1'b0, 1'b0, 1'b0, 2'b11, b);
      check(mism_cnt == mc + 1, "R5 mismatch pulse", mism_cnt - mc, 1);
      read_byte(got);
      check(got == 8'(1 << b), "R5 majority tie high", got, 1 << b);
    end

    // R6 R7 overflow: 16 fill FIFO, 17th waits in holding, 18th dropped
    for (int i = 0; i < 18; i++)
      send_frame(8'(8'h40 + i), 2'd3, 1'b0, 1'b0, 1'b0, 2'b11, -1);
    check(fifo_full == 1'b1, "R7 full at 16", fifo_full, 1);
    for (int i = 0; i < 17; i++) begin
      read_byte(got);
      check(got == 8'(8'h40 + i), "R6 R7 order through hold", got, 8'h40 + i);
      repeat (4) @(negedge clk);
    end
    check(fifo_empty == 1'b1, "R6 eighteenth discarded", fifo_empty, 1);
    // R8 read on empty leaves rd_data unchanged
    read_byte(got);
    check(got == 8'h50, "R8 empty read ignored", got, 8'h50);
    repeat (10) @(negedge clk);
    check(rd_data == 8'h50, "R8 rd_data holds", rd_data, 8'h50);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule